// File: doc/BRIEF.md
# Single-Channel Prescaled PWM Generator

This block produces one pulse-width-modulated output from a programmable period and high-time, both counted in prescaled clock ticks. The source clock is divided by a power of two before it feeds a 10-bit waveform counter. The output is high while the counter is below the high-time and low for the rest of the period. Software programs the block through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. The port exposes two registers.

New timing values never reach the waveform in the middle of a period. Writes land in staging registers. A staged set becomes active at the next period boundary, or at once when the generator is idle. An update-hold bit in the control register freezes this transfer. Software can therefore rewrite period, high-time and prescaler in several bus writes, then release the hold so that all of them take effect together. A zero period or a zero high-time is a prohibited setting, and the generator does not run while either active field is zero.

Top module: `pwm_timer`

## Requirements
- R1: During and right after reset, both registers read 0 and `pwm_out` is low.
- R2: The control register at byte address 0x00 holds the enable in bit 0, a spare select flag in bit 4, the hold flag in bit 11, the low exponent bit in bit 15 and a 4-bit exponent code in bits 19:16. The count register at 0x04 holds the period in bits 25:16 and the high-time in bits 9:0. Reads return the staged values, and all other bits read 0. Any other address reads 0 and ignores writes.
- R3: While running, the output is high for tick counts below the high-time and low from the high-time to period-1, after which the count wraps to 0. Each count lasts 2^n clock cycles, where n = 2*code + low bit, saturated at 24.
- R4: If the active period or the active high-time is zero, the output stays low even when enabled.
- R5: If the active high-time is greater than or equal to the active period, the enabled output stays high.
- R6: With the enable clear, the output is low and both the prescaler and the tick counter return to 0, so that re-enabling starts a fresh period.
- R7: While the hold flag is set, writes to the count register or the exponent fields do not change the waveform.
- R8: A staged set, including the exponent, becomes active as one unit. This happens on the clock edge after the write when the generator is not running, or on the edge that ends a period when it is running, and only while the hold flag is clear.
- R9: Read data reflects the addressed register in the same cycle as the address, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
Read data is due in the cycle the address is presented. A written value shows in the readback after the next rising edge. The output is a combinational function of registered state, so any change is visible just after the edge that caused it. When idle, a staged set becomes active one edge after its write. When running, it becomes active on the edge where the last prescaled tick of the period completes. The bench drives inputs and samples outputs at the falling edge. It steps a cycle model of these rules at the same point, so that every comparison is made half a cycle after the edge that produced the value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 10;
    localparam int MAX_EXP  = 24;
    localparam int EXP_W    = $clog2(MAX_EXP + 1);
    localparam int CC_W     = 4;
    localparam int RAW_W    = CC_W + 1;
    localparam int PRE_W    = MAX_EXP;

    localparam int OFS_CTRL  = 0;
    localparam int OFS_COUNT = 4;

    localparam int B_EN      = 0;
    localparam int B_SEL     = 4;
    localparam int B_HOLD    = 11;
    localparam int B_CCMD    = 15;
    localparam int B_CC_LO   = 16;
    localparam int B_PER_LO  = 16;
    localparam int B_HIGH_LO = 0;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [EXP_W-1:0]   exp_t;

    typedef struct packed {
        field_t period;
        field_t high;
        exp_t   shift;
    } timing_t;

    typedef struct packed {
        logic            en;
        logic            sel;
        logic            hold;
        logic [CC_W-1:0] cc;
        logic            ccmd;
    } ctrl_t;

    function automatic exp_t div_exponent(input logic [CC_W-1:0] cc, input logic ccmd);
        logic [RAW_W-1:0] raw;
        raw = {cc, ccmd};
        if (raw > RAW_W'(MAX_EXP))
            return exp_t'(MAX_EXP);
        return exp_t'(raw);
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_EN]               = c.en;
        w[B_SEL]              = c.sel;
        w[B_HOLD]             = c.hold;
        w[B_CCMD]             = c.ccmd;
        w[B_CC_LO +: CC_W]    = c.cc;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_count(input field_t per, input field_t high);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_PER_LO +: FIELD_W]  = per;
        w[B_HIGH_LO +: FIELD_W] = high;
        return w;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              boundary,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output timing_t           active,
    output logic              running
);

    ctrl_t   ctrl_q;
    field_t  per_q;
    field_t  high_q;
    logic    pend_q;
    timing_t act_q;

    logic hit_ctrl;
    logic hit_count;
    logic wr_ctrl;
    logic wr_count;
    logic apply;

    assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign hit_count = (addr == ADDR_W'(OFS_COUNT));
    assign wr_ctrl   = we && hit_ctrl;
    assign wr_count  = we && hit_count;

    // Generator runs only with a legal (non-zero) active set.
    assign running = ctrl_q.en && (act_q.period != '0) && (act_q.high != '0);

    // Transfer staged set when released and idle or at a period wrap.
    assign apply = pend_q && !ctrl_q.hold && (!running || boundary);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            high_q <= '0;
            pend_q <= 1'b0;
            act_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en   <= wdata[B_EN];
                ctrl_q.sel  <= wdata[B_SEL];
                ctrl_q.hold <= wdata[B_HOLD];
                ctrl_q.ccmd <= wdata[B_CCMD];
                ctrl_q.cc   <= wdata[B_CC_LO +: CC_W];
            end
            if (wr_count) begin
                per_q  <= wdata[B_PER_LO +: FIELD_W];
                high_q <= wdata[B_HIGH_LO +: FIELD_W];
            end
            if (apply) begin
                act_q.period <= per_q;
                act_q.high   <= high_q;
                act_q.shift  <= div_exponent(ctrl_q.cc, ctrl_q.ccmd);
            end
            if (wr_ctrl || wr_count)
                pend_q <= 1'b1;
            else if (apply)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl)
            rdata = pack_ctrl(ctrl_q);
        else if (hit_count)
            rdata = pack_count(per_q, high_q);
    end

    assign ctrl   = ctrl_q;
    assign active = act_q;

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  exp_t             shift,
    output logic             tick,
    output logic [PRE_W-1:0] pre_cnt
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    // 2^shift - 1; a shift equal to the width yields all ones.
    assign limit = ~({PRE_W{1'b1}} << shift);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign pre_cnt = cnt_q;

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   tick,
    input  field_t period,
    input  field_t high,
    output field_t cnt,
    output logic   boundary,
    output logic   wave
);

    field_t cnt_q;
    field_t last;

    assign last     = field_t'(period - field_t'(1));
    assign boundary = tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (boundary)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign wave = run && (cnt_q < high);
    assign cnt  = cnt_q;

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_out
);

    ctrl_t            ctrl_w;
    timing_t          act_w;
    logic             run_w;
    logic             tick_w;
    logic             bnd_w;
    logic             en_w;
    logic             hold_w;
    field_t           cnt_w;
    logic [PRE_W-1:0] pre_w;

    pwm_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .boundary (bnd_w),
        .rdata    (reg_rdata),
        .ctrl     (ctrl_w),
        .active   (act_w),
        .running  (run_w)
    );

    pwm_prescaler pre_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run_w),
        .shift   (act_w.shift),
        .tick    (tick_w),
        .pre_cnt (pre_w)
    );

    pwm_wave wave_i (
        .clk      (clk),
        .rst      (rst),
        .run      (run_w),
        .tick     (tick_w),
        .period   (act_w.period),
        .high     (act_w.high),
        .cnt      (cnt_w),
        .boundary (bnd_w),
        .wave     (pwm_out)
    );

    assign en_w   = ctrl_w.en;
    assign hold_w = ctrl_w.hold;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             hold,
    input logic             run,
    input timing_t          act,
    input field_t           cnt,
    input logic [PRE_W-1:0] pre,
    input logic             pwm
);

    a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm);

    a_r6_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && pre == '0));

    a_r4_zero_blocks: assert property (@(posedge clk) disable iff (rst)
        (act.period == '0 || act.high == '0) |-> !pwm);

    a_r5_full_high: assert property (@(posedge clk) disable iff (rst)
        (run && act.high >= act.period) |-> pwm);

    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < act.period));

    a_r7_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(act));

    a_r8_swap_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(act)) |-> (cnt == '0 && pre == '0));

endmodule

bind pwm_timer pwm_timer_chk chk_i (
    .clk  (clk),
    .rst  (rst),
    .en   (en_w),
    .hold (hold_w),
    .run  (run_w),
    .act  (act_w),
    .cnt  (cnt_w),
    .pre  (pre_w),
    .pwm  (pwm_out)
);

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_timer #(.ADDR_W(4)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    // Reference state built from the requirements.
    bit       m_en, m_sel, m_hold, m_ccmd, m_pend;
    bit [3:0] m_cc;
    int       m_per, m_high, m_aper, m_ahigh, m_aexp, m_pre, m_cnt;

    function automatic bit m_running();
        return m_en && m_aper != 0 && m_ahigh != 0;
    endfunction

    function automatic bit m_out();
        return m_running() && (m_cnt < m_ahigh);
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 4'd0) begin
            r[0] = m_en; r[4] = m_sel; r[11] = m_hold; r[15] = m_ccmd; r[19:16] = m_cc;
        end else if (a == 4'd4) begin
            r[25:16] = 10'(m_per); r[9:0] = 10'(m_high);
        end
        return r;
    endfunction

    function automatic logic [31:0] ctrl_word(input bit en, input bit hold, input int cc, input bit ccmd);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[11] = hold; w[15] = ccmd; w[19:16] = 4'(cc);
        return w;
    endfunction

    function automatic logic [31:0] count_word(input int per, input int high);
        logic [31:0] w;
        w = '0;
        w[25:16] = 10'(per); w[9:0] = 10'(high);
        return w;
    endfunction

    task automatic model_step(input logic we, input logic [3:0] a, input logic [31:0] d);
        bit run, tick, bnd, app;
        int lim, nexp;
        run  = m_running();
        lim  = (1 << m_aexp) - 1;
        tick = run && (m_pre == lim);
        bnd  = tick && (m_cnt == m_aper - 1);
        app  = m_pend && !m_hold && (!run || bnd);
        nexp = 2 * int'(m_cc) + int'(m_ccmd);
        if (nexp > 24) nexp = 24;
        if (!run) begin m_pre = 0; m_cnt = 0; end
        else if (tick) begin m_pre = 0; m_cnt = bnd ? 0 : m_cnt + 1; end
        else m_pre = m_pre + 1;
        if (app) begin m_aper = m_per; m_ahigh = m_high; m_aexp = nexp; end
        if (we && a == 4'd0) begin
            m_en = d[0]; m_sel = d[4]; m_hold = d[11]; m_ccmd = d[15]; m_cc = d[19:16];
        end
        if (we && a == 4'd4) begin
            m_per = int'(d[25:16]); m_high = int'(d[9:0]);
        end
        if (we && (a == 4'd0 || a == 4'd4)) m_pend = 1;
        else if (app) m_pend = 0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: sample at the falling edge, then drive and step the model.
    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input bit rchk, input string tag);
        logic [31:0] rexp;
        @(negedge clk);
        chk(32'(pwm_out), 32'(m_out()), tag, "pwm_out");
        reg_we = we; reg_addr = a; reg_wdata = d;
        rexp = m_read(a);
        if (rchk) begin
            #1;
            chk(reg_rdata, rexp, tag, "rdata");
        end
        model_step(we, a, d);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, '0, 1'b0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1'b0, a, '0, 1'b1, tag);
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: values during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        reg_addr = 4'd0; #1;
        chk(reg_rdata, 32'h0, "R1", "ctrl during reset");
        chk(32'(pwm_out), 32'h0, "R1", "pwm during reset");
        reg_addr = 4'd4; #1;
        chk(reg_rdata, 32'h0, "R1", "count during reset");
        rst = 1'b0;
        rd(4'd0, "R1");
        rd(4'd4, "R1");

        // R2 / R9: layout, unused bits, stray address
        wr(4'd0, 32'hFFFF_FFFF, "R2");
        rd(4'd0, "R2");
        chk(reg_rdata, 32'h000F_8811, "R2", "ctrl all ones");
        wr(4'd0, 32'h0, "R2");
        wr(4'd4, 32'hFFFF_FFFF, "R2");
        rd(4'd4, "R9");
        chk(reg_rdata, 32'h03FF_03FF, "R2", "count all ones");
        wr(4'd8, 32'hFFFF_FFFF, "R2");
        rd(4'd8, "R2");
        rd(4'd4, "R2");
        chk(reg_rdata, 32'h03FF_03FF, "R2", "count after stray write");

        // R4: zero high-time, then zero period
        wr(4'd4, count_word(5, 0), "R4");
        wr(4'd0, ctrl_word(1, 0, 0, 0), "R4");
        idle(20, "R4");
        chk(32'(pwm_out), 32'h0, "R4", "zero high");
        wr(4'd4, count_word(0, 3), "R4");
        idle(20, "R4");
        chk(32'(pwm_out), 32'h0, "R4", "zero period");

        // R5: high-time equal to and above period
        wr(4'd4, count_word(4, 4), "R5");
        idle(20, "R5");
        chk(32'(pwm_out), 32'h1, "R5", "high == period");
        wr(4'd4, count_word(3, 9), "R5");
        idle(20, "R5");
        chk(32'(pwm_out), 32'h1, "R5", "high > period");

        // R3: basic waveform with exponents 0..3
        for (int e = 0; e < 4; e++) begin
            wr(4'd0, ctrl_word(0, 0, e / 2, 1'(e % 2)), "R6");
            wr(4'd4, count_word(5, 2), "R3");
            idle(2, "R3");
            wr(4'd0, ctrl_word(1, 0, e / 2, 1'(e % 2)), "R3");
            idle(12 * (1 << e), "R3");
        end

        // R6: disable mid-period then restart
        wr(4'd0, ctrl_word(0, 0, 0, 1), "R6");
        idle(1, "R6");
        chk(32'(pwm_out), 32'h0, "R6", "disabled output");
        wr(4'd0, ctrl_word(1, 0, 0, 1), "R6");
        idle(1, "R6");
        chk(32'(pwm_out), 32'h1, "R6", "restart high");
        idle(15, "R6");

        // R7 / R8: staged change under hold, released later
        wr(4'd0, ctrl_word(1, 1, 0, 1), "R7");
        wr(4'd4, count_word(9, 7), "R7");
        wr(4'd0, ctrl_word(1, 1, 1, 0), "R7");
        idle(30, "R7");
        wr(4'd0, ctrl_word(1, 0, 1, 0), "R8");
        idle(80, "R8");

        // Random mix checked cycle by cycle against the model
        for (int it = 0; it < 250; it++) begin
            int op;
            op = $urandom_range(0, 3);
            if (op < 2)
                wr(4'd4, count_word($urandom_range(0, 12), $urandom_range(0, 14)), "R8");
            else
                wr(4'd0, ctrl_word($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 3,
                                   $urandom_range(0, 1), 1'($urandom_range(0, 1))), "R7");
            idle($urandom_range(0, 40), "R3");
        end

        done = 1;
        report();
    end

endmodule